// File: doc/BRIEF.md
# Canonic Signed Digit Recoder

This block turns an N-bit binary word into its canonic signed digit (CSD) form. Every output digit is +1, 0 or -1. Each digit travels as a pair of bits, a sign bit and a data bit, and the digit's value is the data bit minus the sign bit. The CSD form is unique for each value. It never places two nonzero digits next to each other, and it uses the fewest nonzero digits of any signed-digit form. A constant multiplier that consumes it therefore needs the smallest number of add or subtract terms.

A mode input chooses how the word is read. In unsigned mode the word becomes N+1 digits. In two's complement mode it becomes N digits, and the extra top digit is held at zero. The recoding carry is never built as one chain. Two short recurrences run side by side, one alternating AND/OR and one alternating OR/AND. Every digit is taken from neighbouring bits of these two recurrences. A parameter can replace the plain ripple of both recurrences with a grouped look-ahead form that steps four bits at a time. The recoded result is registered, so it appears one clock after the input.

Top module: `csd_recoder`

## Requirements
- R1: Each digit i appears as the pair (dig_s[i], dig_d[i]) with value dig_d[i] - dig_s[i]. The encoding is 00 for 0, 01 for +1 and 10 for -1. The pair 11 is never produced.
- R2: With is_signed = 0, the sum over digits 0..N of value(i)·2^i equals bin_in read as an unsigned integer.
- R3: With is_signed = 1, digit N is 00, and the sum over digits 0..N-1 of value(i)·2^i equals bin_in read as a two's complement integer.
- R4: No two adjacent digits are both nonzero.
- R5: The digit vector equals the unique CSD form of the value, so its count of nonzero digits is minimal.
- R6: With is_signed = 0, digits N and N-1 are never -1.
- R7: While rst_n is low, both digit outputs are all zero. Otherwise the outputs show the recoding of the bin_in and is_signed values that were present at the previous rising clock edge, and they do not change between edges.
- R8: Digit 0 is +1 when bin_in[0]=1 and bin_in[1]=0, -1 when both bits are 1, and 0 otherwise.
- R9: For N=8 in unsigned mode, input 87 (binary 01010111) gives -1 at digit positions 0, 3 and 5, +1 at position 7, and zero at every other position.
- R10: The grouped look-ahead build (LOOKAHEAD=1, N a multiple of 4) and the ripple build give identical outputs for every input and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the result register |
| bin_in | input | N | Binary word to recode |
| is_signed | input | 1 | 0: unsigned interpretation, 1: two's complement interpretation |
| dig_s | output | N+1 | Sign bit of each digit, index = digit position |
| dig_d | output | N+1 | Data bit of each digit, index = digit position |

## Verification
Sign extension and the carry out of a long run of ones both meet at the top two digits, and they do so in the same result. Digit N-1 must absorb both the extended sign and the carry arriving from the lower bits. The sweep provokes this with words such as all ones, a lone top bit, and a top zero above a run of ones, in each mode. Every output is judged against a CSD form computed arithmetically in the bench, by repeatedly peeling off the value modulo 4. The bench also checks the signed digit sum against the input value and compares the look-ahead build with the ripple build.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // number interpretation selected by the mode input
    typedef enum logic {
        NUM_UNSIGNED = 1'b0,
        NUM_TWOS     = 1'b1
    } num_mode_e;

    // digit pair encoding {sign, data}
    localparam logic [1:0] DIG_ZERO = 2'b00;
    localparam logic [1:0] DIG_POS  = 2'b01;
    localparam logic [1:0] DIG_NEG  = 2'b10;

endpackage

// File: rtl/csd_hk_ripple.sv
// Plain ripple of the two parallel recurrences over W bits.
// Odd index:  h = x & h_prev, k = x | k_prev
// Even index: h = x | h_prev, k = x & k_prev   (both start from 0)
module csd_hk_ripple #(
    parameter int W = 9
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] h,
    output logic [W-1:0] k
);

    always_comb begin
        logic hp;
        logic kp;
        hp = 1'b0;
        kp = 1'b0;
        for (int i = 0; i < W; i++) begin
            if ((i % 2) == 1) begin
                h[i] = x[i] & hp;
                k[i] = x[i] | kp;
            end else begin
                h[i] = x[i] | hp;
                k[i] = x[i] & kp;
            end
            hp = h[i];
            kp = k[i];
        end
    end

endmodule

// File: rtl/csd_hk_lookahead.sv
// Grouped form: anchors at indices 2, 6, 10, ... step four bits at a time
// using group generate/propagate terms; the bits between anchors ripple
// locally from the nearest anchor below, so anchors never wait on them.
module csd_hk_lookahead #(
    parameter int W = 9
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] h,
    output logic [W-1:0] k
);

    localparam int FIRST_ANCHOR = 2;
    localparam int GROUP        = 4;

    always_comb begin
        logic hp;
        logic kp;
        logic ha;
        logic ka;
        logic gh;
        logic ph;
        logic gk;
        logic pk;
        // bits below and at the first anchor
        h[0] = x[0];
        k[0] = 1'b0;
        h[1] = x[1] & x[0];
        k[1] = x[1];
        h[2] = x[2] | (x[1] & x[0]);
        k[2] = x[2] & x[1];
        ha = h[2];
        ka = k[2];
        hp = h[2];
        kp = k[2];
        for (int i = FIRST_ANCHOR + 1; i < W; i++) begin
            if (((i - FIRST_ANCHOR) % GROUP) == 0) begin
                gh = x[i] | (x[i-1] & x[i-2]);
                ph = x[i-1] & x[i-3];
                gk = x[i] & (x[i-1] | x[i-2]);
                pk = x[i-1] | x[i-3];
                h[i] = gh | (ph & ha);
                k[i] = gk & (pk | ka);
                ha = h[i];
                ka = k[i];
            end else if ((i % 2) == 1) begin
                h[i] = x[i] & hp;
                k[i] = x[i] | kp;
            end else begin
                h[i] = x[i] | hp;
                k[i] = x[i] & kp;
            end
            hp = h[i];
            kp = k[i];
        end
    end

endmodule

// File: rtl/csd_digit_gen.sv
// Forms every digit pair from neighbouring recurrence bits.
// carry(m) = h[m] | k[m+1] for odd m, h[m+1] | k[m] for even m.
module csd_digit_gen
    import csd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N:0] x,
    input  logic [N:0] h,
    input  logic [N:0] k,
    input  num_mode_e  mode,
    output logic [N:0] s,
    output logic [N:0] d
);

    localparam bit TOP_ODD = ((N - 1) % 2) == 1;

    // only odd h and even k feed carries; the rest are intermediate
    logic hk_sink_unused;
    assign hk_sink_unused = ^{h, k};

    for (genvar i = 0; i < N; i++) begin : g_dig
        logic cin;
        logic nz;
        if (i == 0) begin : g_c0
            assign cin = 1'b0;
        end else if (((i - 1) % 2) == 1) begin : g_codd
            assign cin = h[i-1] | k[i];
        end else begin : g_ceven
            assign cin = h[i] | k[i-1];
        end
        assign nz   = x[i] ^ cin;
        assign d[i] = nz & ~x[i+1];
        assign s[i] = nz &  x[i+1];
    end

    logic c_top;
    if (TOP_ODD) begin : g_top_odd
        assign c_top = h[N-1] | k[N];
    end else begin : g_top_even
        assign c_top = h[N] | k[N-1];
    end

    // extra digit exists only for unsigned words and is never negative
    assign d[N] = (mode == NUM_UNSIGNED) & c_top;
    assign s[N] = 1'b0;

endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
    import csd_pkg::*;
#(
    parameter int N         = 8,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] bin_in,
    input  logic         is_signed,
    output logic [N:0]   dig_s,
    output logic [N:0]   dig_d
);

    localparam int W = N + 1;

    if (N < 4) begin : g_bad_width
        $error("csd_recoder: N must be at least 4");
    end
    if (LOOKAHEAD && ((N % 4) != 0)) begin : g_bad_group
        $error("csd_recoder: look-ahead needs N a multiple of 4");
    end

    typedef struct packed {
        logic       mode;
        logic [N:0] s;
        logic [N:0] d;
    } rec_t;

    rec_t st_d;
    rec_t st_q;

    num_mode_e  mode_w;
    logic [N:0] x_ext;
    logic [N:0] h_w;
    logic [N:0] k_w;
    logic [N:0] s_w;
    logic [N:0] d_w;

    assign mode_w = num_mode_e'(is_signed);
    assign x_ext  = {(mode_w == NUM_TWOS) & bin_in[N-1], bin_in};

    if (LOOKAHEAD) begin : g_la
        csd_hk_lookahead #(.W(W)) u_hk (
            .x (x_ext),
            .h (h_w),
            .k (k_w)
        );
    end else begin : g_rip
        csd_hk_ripple #(.W(W)) u_hk (
            .x (x_ext),
            .h (h_w),
            .k (k_w)
        );
    end

    csd_digit_gen #(.N(N)) u_dig (
        .x    (x_ext),
        .h    (h_w),
        .k    (k_w),
        .mode (mode_w),
        .s    (s_w),
        .d    (d_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = is_signed;
        st_d.s    = s_w;
        st_d.d    = d_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dig_s = st_q.s;
    assign dig_d = st_q.d;

    // R1
    no_pair11_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_s & dig_d) == '0);

    // R4
    no_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((dig_s | dig_d) & ((dig_s | dig_d) >> 1)) == '0));

    // R6
    top_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode |-> (!dig_s[N] && !dig_s[N-1]));

    // R3
    signed_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode |-> (!dig_s[N] && !dig_d[N]));

    // R8
    digit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dig_d[0] == ($past(bin_in[0]) & ~$past(bin_in[1])))
               && (dig_s[0] == ($past(bin_in[0]) &  $past(bin_in[1])))));

    // R7
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_in == '0) |=> ((dig_s == '0) && (dig_d == '0)));

endmodule

// File: tb/tb_csd_recoder.sv
module tb_csd_recoder;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] bin_in = '0;
    logic         is_signed = 1'b0;
    logic [N:0]   dig_s, dig_d, la_s, la_d;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    csd_recoder #(.N(N), .LOOKAHEAD(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bin_in(bin_in), .is_signed(is_signed),
        .dig_s(dig_s), .dig_d(dig_d));

    csd_recoder #(.N(N), .LOOKAHEAD(1'b1)) dut_la (
        .clk(clk), .rst_n(rst_n), .bin_in(bin_in), .is_signed(is_signed),
        .dig_s(la_s), .dig_d(la_d));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // unique CSD by peeling the value modulo 4
    task automatic ref_csd(input longint val, output logic [N:0] rs, output logic [N:0] rd);
        longint v;
        v = val;
        rs = '0;
        rd = '0;
        for (int i = 0; i <= N; i++) begin
            if ((v & 1) != 0) begin
                if ((v & 3) == 1) begin
                    rd[i] = 1'b1;
                    v = v - 1;
                end else begin
                    rs[i] = 1'b1;
                    v = v + 1;
                end
            end
            v = v >>> 1;
        end
    endtask

    function automatic longint digit_sum(input logic [N:0] s, input logic [N:0] d);
        longint acc;
        acc = 0;
        for (int i = 0; i <= N; i++) begin
            acc = acc + ((longint'(d[i]) - longint'(s[i])) <<< i);
        end
        return acc;
    endfunction

    task automatic apply(input logic [N-1:0] v, input logic sg);
        @(negedge clk);
        bin_in = v;
        is_signed = sg;
        @(negedge clk);
    endtask

    task automatic check_vec(input logic [N-1:0] v, input logic sg);
        longint     val;
        logic [N:0] es, ed;
        logic [N:0] nz;
        val = sg ? longint'($signed(v)) : longint'(v);
        ref_csd(val, es, ed);
        nz = dig_s | dig_d;
        chk((dig_s & dig_d) == '0, "R1 pair 11", longint'(dig_s & dig_d), 0);
        if (sg) begin
            chk(digit_sum(dig_s, dig_d) == val, "R3 signed sum", digit_sum(dig_s, dig_d), val);
            chk(!dig_s[N] && !dig_d[N], "R3 top digit zero", longint'({dig_s[N], dig_d[N]}), 0);
        end else begin
            chk(digit_sum(dig_s, dig_d) == val, "R2 unsigned sum", digit_sum(dig_s, dig_d), val);
            chk(!dig_s[N] && !dig_s[N-1], "R6 top digits nonneg", longint'(dig_s[N:N-1]), 0);
        end
        chk((nz & (nz >> 1)) == '0, "R4 adjacency", longint'(nz), 0);
        chk({dig_s, dig_d} == {es, ed}, "R5 canonical form", longint'({dig_s, dig_d}), longint'({es, ed}));
        chk({dig_d[0], dig_s[0]} == {v[0] & ~v[1], v[0] & v[1]}, "R8 digit 0",
            longint'({dig_s[0], dig_d[0]}), longint'({v[0] & v[1], v[0] & ~v[1]}));
        chk({la_s, la_d} == {dig_s, dig_d}, "R10 look-ahead match",
            longint'({la_s, la_d}), longint'({dig_s, dig_d}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R7 reset state
        repeat (3) @(negedge clk);
        bin_in = 8'hA5;
        @(negedge clk);
        chk(dig_s == '0 && dig_d == '0, "R7 reset clears", longint'({dig_s, dig_d}), 0);
        rst_n = 1'b1;

        // R9 worked example, 87 unsigned
        apply(8'd87, 1'b0);
        chk(dig_d == 9'b0_1000_0000, "R9 example data", longint'(dig_d), 9'h080);
        chk(dig_s == 9'b0_0010_1001, "R9 example sign", longint'(dig_s), 9'h029);

        // R7 one-cycle latency: output holds until the next edge
        @(negedge clk);
        bin_in = 8'd5;
        #1;
        chk(dig_s == 9'h029 && dig_d == 9'h080, "R7 hold before edge",
            longint'({dig_s, dig_d}), longint'({9'h029, 9'h080}));
        @(negedge clk);
        chk(dig_d == 9'h005 && dig_s == '0, "R7 update after edge",
            longint'({dig_s, dig_d}), longint'({9'h000, 9'h005}));

        // corner words in both modes: sign extension meets a long carry
        for (int sg = 0; sg < 2; sg++) begin
            apply('1, sg[0]);                 check_vec('1, sg[0]);
            apply({1'b1, {(N-1){1'b0}}}, sg[0]); check_vec({1'b1, {(N-1){1'b0}}}, sg[0]);
            apply({1'b0, {(N-1){1'b1}}}, sg[0]); check_vec({1'b0, {(N-1){1'b1}}}, sg[0]);
            apply('0, sg[0]);                 check_vec('0, sg[0]);
        end

        // exhaustive sweep for small widths, random otherwise
        for (int sg = 0; sg < 2; sg++) begin
            if (N <= 12) begin
                for (int v = 0; v < (1 << N); v++) begin
                    apply(v[N-1:0], sg[0]);
                    check_vec(v[N-1:0], sg[0]);
                end
            end else begin
                for (int n = 0; n < 3000; n++) begin
                    logic [N-1:0] rv;
                    rv = N'($urandom);
                    apply(rv, sg[0]);
                    check_vec(rv, sg[0]);
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule